// File: doc/BRIEF.md
# Single-Wire Command Slave Interface

This block is the device end of an asynchronous single-wire serial link. The line idles high and is pulled low by either side through an open-drain driver. Each bit is one low pulse followed by a return to high. The width of the low pulse carries the value: a short low is a 1 and a longer low is a 0. Bytes travel least significant bit first.

A transaction opens with a command byte. Bit 7 of the command picks the direction and bits 6:0 pick one of 128 registers. For a write, the next eight bits received are stored into the addressed register through a one-cycle write strobe. For a read, the slave waits a turnaround time and then sends the addressed register's value back over the same wire, using the same pulse-width code.

A low pulse long enough to be a break cancels whatever is in progress and releases the line. The receiver then accepts nothing until the line has been high for a recovery time. A low pulse that is too long to be a 0 but too short to be a break is treated as a framing error and clears a partly received byte. All widths are counted in clock cycles of the block's own clock.

Top module: `sw_cmd_slave`

## Requirements
- R1: After reset the block does not pull the line (pull_o = 0), rf_we_o is 0, and the receiver waits for a command byte.
- R2: A received low pulse of w cycles decodes as a 1 when w < ONE_MAX_CYC, and as a 0 when ONE_MAX_CYC <= w <= ZERO_MAX_CYC. Bits are assembled least significant first.
- R3: In a command byte, bit 7 = 1 means write and bit 7 = 0 means read. Bits 6:0 are the register address, which is presented on rf_addr_o.
- R4: For a write, after the eighth data bit rf_we_o is high for exactly one cycle, with the command's address on rf_addr_o and the received byte on rf_wdata_o. rf_we_o stays low at all other times.
- R5: For a read, the first slave pulse starts no sooner than TURN_CYC cycles after the command's last bit ends. The slave then sends rf_rdata_i for the addressed register as eight bits, least significant first. A 1 is sent as a pull of exactly TX_ONE_CYC cycles and a 0 as a pull of exactly TX_ZERO_CYC cycles. Each pull is followed by TX_GAP_CYC released cycles.
- R6: A low pulse with ZERO_MAX_CYC < w < BREAK_CYC discards any partial command or data byte. The next pulse is taken as bit 0 of a new command.
- R7: A low lasting BREAK_CYC cycles or more aborts any transaction in progress, including a read being transmitted. pull_o is released the cycle after the break is recognised and stays low afterwards.
- R8: After a break, low pulses are ignored until the line has stayed high for RECOV_CYC consecutive cycles. Only then is a new command accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Sensed level of the shared wire (asynchronous) |
| pull_o | output | 1 | Open-drain enable: 1 pulls the wire low |
| rf_addr_o | output | 7 | Register address from the last command |
| rf_we_o | output | 1 | One-cycle write strobe |
| rf_wdata_o | output | 8 | Byte to write |
| rf_rdata_i | input | 8 | Register file read data for rf_addr_o |

## Verification
The bench builds the block with ONE_MAX_CYC=8, ZERO_MAX_CYC=20, BREAK_CYC=40, RECOV_CYC=10 and TURN_CYC=12. It sends with TX_ONE_CYC=4, TX_ZERO_CYC=14 and TX_GAP_CYC=6. These short windows let the host model drive pulses of exactly 7, 8, 20, 21, 39 and 40 cycles, so every decode threshold is hit on both sides within a short run. The same windows allow recovery to be interrupted by pulses spaced closer than RECOV_CYC, and allow a break to be laid across a read that is still transmitting. Read data comes from a fixed function of the address, which makes any misaligned command visible as a wrong byte.

// File: rtl/sw_cmd_pkg.sv
`timescale 1ns/1ps
package sw_cmd_pkg;
  localparam int unsigned CMD_W  = 8;
  localparam int unsigned ADDR_W = CMD_W - 1;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_DATA,
    ST_RDLAT,
    ST_TX,
    ST_BRK
  } link_st_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_TURN,
    TX_LOW,
    TX_GAP
  } tx_st_e;

  typedef struct packed {
    logic bit_vld;
    logic bit_val;
    logic err;
    logic brk;
  } rx_evt_t;
endpackage

// File: rtl/sw_line_rx.sv
`timescale 1ns/1ps
module sw_line_rx
  import sw_cmd_pkg::*;
#(
  parameter int unsigned ONE_MAX_CYC  = 60,
  parameter int unsigned ZERO_MAX_CYC = 150,
  parameter int unsigned BREAK_CYC    = 190
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    line_i,
  output rx_evt_t evt_o,
  output logic    line_hi_o
);
  localparam int unsigned CW = $clog2(BREAK_CYC + 1);

  logic [1:0]    sync_q;
  logic          line_q;
  logic          prev_q;
  logic [CW-1:0] low_cnt_q;
  logic          rise;
  rx_evt_t       evt_d, evt_q;

  assign line_q = sync_q[1];
  assign rise   = line_q & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 2'b11;
      prev_q    <= 1'b1;
      low_cnt_q <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      prev_q <= line_q;
      if (!line_q) begin
        if (low_cnt_q != CW'(BREAK_CYC)) low_cnt_q <= low_cnt_q + CW'(1);
      end else begin
        low_cnt_q <= '0;
      end
    end
  end

  // low_cnt_q holds the finished pulse width on the rising cycle
  always_comb begin
    evt_d = '0;
    if (rise) begin
      if (low_cnt_q < CW'(ONE_MAX_CYC)) begin
        evt_d.bit_vld = 1'b1;
        evt_d.bit_val = 1'b1;
      end else if (low_cnt_q <= CW'(ZERO_MAX_CYC)) begin
        evt_d.bit_vld = 1'b1;
      end else if (low_cnt_q < CW'(BREAK_CYC)) begin
        evt_d.err = 1'b1;
      end
    end else if (!line_q && low_cnt_q == CW'(BREAK_CYC - 1)) begin
      evt_d.brk = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= evt_d;
  end

  assign evt_o     = evt_q;
  assign line_hi_o = line_q;
endmodule

// File: rtl/sw_bit_tx.sv
`timescale 1ns/1ps
module sw_bit_tx
  import sw_cmd_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned TURN_CYC    = 190,
  parameter int unsigned TX_ONE_CYC  = 35,
  parameter int unsigned TX_ZERO_CYC = 110,
  parameter int unsigned TX_GAP_CYC  = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              abort_i,
  output logic              pull_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned M0 = (TURN_CYC > TX_ZERO_CYC) ? TURN_CYC : TX_ZERO_CYC;
  localparam int unsigned M1 = (M0 > TX_GAP_CYC) ? M0 : TX_GAP_CYC;
  localparam int unsigned M2 = (M1 > TX_ONE_CYC) ? M1 : TX_ONE_CYC;
  localparam int unsigned CW = $clog2(M2 + 1);
  localparam int unsigned IW = $clog2(BYTE_W);

  tx_st_e            st_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [BYTE_W-1:0] sh_q;
  logic              done_q;
  logic              cnt_end;

  assign cnt_end = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        st_q <= TX_IDLE;
      end else begin
        unique case (st_q)
          TX_IDLE: if (start_i) begin
            st_q  <= TX_TURN;
            cnt_q <= CW'(TURN_CYC - 1);
            sh_q  <= data_i;
            idx_q <= '0;
          end
          TX_TURN, TX_GAP: begin
            if (!cnt_end) begin
              cnt_q <= cnt_q - CW'(1);
            end else if (st_q == TX_GAP && idx_q == IW'(BYTE_W - 1)) begin
              st_q   <= TX_IDLE;
              done_q <= 1'b1;
            end else begin
              if (st_q == TX_GAP) begin
                idx_q <= idx_q + IW'(1);
                sh_q  <= sh_q >> 1;
              end
              st_q <= TX_LOW;
              // bit to send is sh_q[0] after the shift
              if (st_q == TX_GAP) cnt_q <= sh_q[1] ? CW'(TX_ONE_CYC - 1) : CW'(TX_ZERO_CYC - 1);
              else                cnt_q <= sh_q[0] ? CW'(TX_ONE_CYC - 1) : CW'(TX_ZERO_CYC - 1);
            end
          end
          TX_LOW: begin
            if (!cnt_end) begin
              cnt_q <= cnt_q - CW'(1);
            end else begin
              st_q  <= TX_GAP;
              cnt_q <= CW'(TX_GAP_CYC - 1);
            end
          end
          default: st_q <= TX_IDLE;
        endcase
      end
    end
  end

  assign pull_o = (st_q == TX_LOW);
  assign busy_o = (st_q != TX_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/sw_cmd_slave.sv
`timescale 1ns/1ps
module sw_cmd_slave
  import sw_cmd_pkg::*;
#(
  parameter int unsigned ONE_MAX_CYC  = 60,
  parameter int unsigned ZERO_MAX_CYC = 150,
  parameter int unsigned BREAK_CYC    = 190,
  parameter int unsigned RECOV_CYC    = 40,
  parameter int unsigned TURN_CYC     = 190,
  parameter int unsigned TX_ONE_CYC   = 35,
  parameter int unsigned TX_ZERO_CYC  = 110,
  parameter int unsigned TX_GAP_CYC   = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output logic              pull_o,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic              rf_we_o,
  output logic [CMD_W-1:0]  rf_wdata_o,
  input  logic [CMD_W-1:0]  rf_rdata_i
);
  localparam int unsigned BCW = $clog2(CMD_W);
  localparam int unsigned RCW = $clog2(RECOV_CYC + 1);

  rx_evt_t           rx_evt;
  logic              line_hi;
  link_st_e          state_q;
  logic [BCW-1:0]    bcnt_q;
  logic [CMD_W-1:0]  sh_q;
  logic [CMD_W-1:0]  byte_nxt;
  logic              last_bit;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [CMD_W-1:0]  wdata_q;
  logic [RCW-1:0]    hi_cnt_q;
  logic              tx_start;
  logic              tx_abort;
  logic              tx_busy;
  logic              tx_done;

  sw_line_rx #(
    .ONE_MAX_CYC (ONE_MAX_CYC),
    .ZERO_MAX_CYC(ZERO_MAX_CYC),
    .BREAK_CYC   (BREAK_CYC)
  ) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (line_i),
    .evt_o    (rx_evt),
    .line_hi_o(line_hi)
  );

  assign byte_nxt = {rx_evt.bit_val, sh_q[CMD_W-1:1]};
  assign last_bit = (bcnt_q == BCW'(CMD_W - 1));
  assign tx_start = (state_q == ST_RDLAT);
  assign tx_abort = rx_evt.brk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_CMD;
      bcnt_q   <= '0;
      sh_q     <= '0;
      addr_q   <= '0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
      hi_cnt_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (rx_evt.brk) begin
        state_q  <= ST_BRK;
        bcnt_q   <= '0;
        hi_cnt_q <= '0;
      end else begin
        unique case (state_q)
          ST_CMD, ST_DATA: begin
            if (rx_evt.err) begin
              state_q <= ST_CMD;
              bcnt_q  <= '0;
            end else if (rx_evt.bit_vld) begin
              sh_q   <= byte_nxt;
              bcnt_q <= last_bit ? '0 : bcnt_q + BCW'(1);
              if (last_bit) begin
                if (state_q == ST_CMD) begin
                  addr_q  <= byte_nxt[ADDR_W-1:0];
                  state_q <= byte_nxt[CMD_W-1] ? ST_DATA : ST_RDLAT;
                end else begin
                  we_q    <= 1'b1;
                  wdata_q <= byte_nxt;
                  state_q <= ST_CMD;
                end
              end
            end
          end
          ST_RDLAT: state_q <= ST_TX;
          ST_TX:    if (tx_done) state_q <= ST_CMD;
          ST_BRK: begin
            if (!line_hi) begin
              hi_cnt_q <= '0;
            end else if (hi_cnt_q == RCW'(RECOV_CYC - 1)) begin
              hi_cnt_q <= '0;
              state_q  <= ST_CMD;
            end else begin
              hi_cnt_q <= hi_cnt_q + RCW'(1);
            end
          end
          default: state_q <= ST_CMD;
        endcase
      end
    end
  end

  sw_bit_tx #(
    .BYTE_W     (CMD_W),
    .TURN_CYC   (TURN_CYC),
    .TX_ONE_CYC (TX_ONE_CYC),
    .TX_ZERO_CYC(TX_ZERO_CYC),
    .TX_GAP_CYC (TX_GAP_CYC)
  ) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tx_start),
    .data_i (rf_rdata_i),
    .abort_i(tx_abort),
    .pull_o (pull_o),
    .busy_o (tx_busy),
    .done_o (tx_done)
  );

  assign rf_addr_o  = addr_q;
  assign rf_we_o    = we_q;
  assign rf_wdata_o = wdata_q;
endmodule

// File: rtl/sw_cmd_slave_chk.sv
`timescale 1ns/1ps
module sw_cmd_slave_chk
  import sw_cmd_pkg::*;
#(
  parameter int unsigned TX_ZERO_CYC = 110
) (
  input logic     clk_i,
  input logic     rst_ni,
  input logic     pull_o,
  input logic     rf_we_o,
  input rx_evt_t  evt,
  input link_st_e state,
  input logic     tx_busy
);
  localparam int unsigned PW = $clog2(TX_ZERO_CYC + 2);

  logic [PW-1:0] pull_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              pull_run_q <= '0;
    else if (!pull_o)                         pull_run_q <= '0;
    else if (pull_run_q != PW'(TX_ZERO_CYC + 1)) pull_run_q <= pull_run_q + PW'(1);
  end

  p_idle_after_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !pull_o && !rf_we_o);

  p_evt_exclusive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({evt.bit_vld, evt.err, evt.brk}));

  p_we_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> !rf_we_o);

  p_no_we_in_tx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy |-> !rf_we_o);

  p_pull_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_run_q <= PW'(TX_ZERO_CYC));

  p_brk_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt.brk |=> !pull_o);

  p_recov_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_BRK) |-> !pull_o && !rf_we_o);
endmodule

bind sw_cmd_slave sw_cmd_slave_chk #(.TX_ZERO_CYC(TX_ZERO_CYC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pull_o (pull_o),
  .rf_we_o(rf_we_o),
  .evt    (rx_evt),
  .state  (state_q),
  .tx_busy(tx_busy)
);

// File: tb/sw_cmd_slave_test.sv
`timescale 1ns/1ps
module sw_cmd_slave_test;
  localparam int ONE_MAX  = 8;
  localparam int ZERO_MAX = 20;
  localparam int BRK      = 40;
  localparam int RECOV    = 10;
  localparam int TURN     = 12;
  localparam int TX_ONE   = 4;
  localparam int TX_ZERO  = 14;
  localparam int TX_GAP   = 6;
  localparam int H_ONE    = 4;
  localparam int H_ZERO   = 14;
  localparam int H_GAP    = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_pull = 1'b0;
  logic       line;
  logic       pull;
  logic [6:0] rf_addr;
  logic       rf_we;
  logic [7:0] rf_wdata;
  logic [7:0] rf_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int last_rise = 0;
  bit mon_mute = 1'b0;
  bit finished = 1'b0;

  logic [14:0] wq[$];
  logic [7:0]  rq[$];

  function automatic logic [7:0] rd_model(logic [6:0] a);
    return {a, 1'b1} ^ 8'h3C;
  endfunction

  assign line     = ~(host_pull | pull);
  assign rf_rdata = rd_model(rf_addr);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sw_cmd_slave #(
    .ONE_MAX_CYC (ONE_MAX),
    .ZERO_MAX_CYC(ZERO_MAX),
    .BREAK_CYC   (BRK),
    .RECOV_CYC   (RECOV),
    .TURN_CYC    (TURN),
    .TX_ONE_CYC  (TX_ONE),
    .TX_ZERO_CYC (TX_ZERO),
    .TX_GAP_CYC  (TX_GAP)
  ) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .line_i    (line),
    .pull_o    (pull),
    .rf_addr_o (rf_addr),
    .rf_we_o   (rf_we),
    .rf_wdata_o(rf_wdata),
    .rf_rdata_i(rf_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic host_pulse(input int w, input int gap);
    @(posedge clk); #1 host_pull = 1'b1;
    repeat (w) @(posedge clk);
    #1 host_pull = 1'b0;
    last_rise = cyc;
    repeat (gap) @(posedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) host_pulse(b[i] ? H_ONE : H_ZERO, H_GAP);
  endtask

  // threshold widths: 1 -> ONE_MAX-1, 0 -> ONE_MAX or ZERO_MAX
  task automatic send_byte_edge(input logic [7:0] b);
    for (int i = 0; i < 8; i++)
      host_pulse(b[i] ? ONE_MAX - 1 : ((i % 2 == 0) ? ONE_MAX : ZERO_MAX), H_GAP);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d);
    wq.push_back({a, d});
    send_byte({1'b1, a});
    send_byte(d);
    repeat (6) @(posedge clk);
  endtask

  task automatic do_read(input logic [6:0] a);
    rq.push_back(rd_model(a));
    send_byte({1'b0, a});
    repeat (TURN + 8 * (TX_ZERO + TX_GAP) + 20) @(posedge clk);
  endtask

  task automatic check_drained(input string req);
    chk(wq.size() == 0, {req, " writes drained"}, wq.size(), 0);
    chk(rq.size() == 0, {req, " reads drained"}, rq.size(), 0);
  endtask

  // scoreboard monitor
  int         pl_run = 0;
  int         nbits = 0;
  logic [7:0] rbyte = '0;
  logic       pull_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rf_we) begin
        if (wq.size() == 0) chk(1'b0, "R4 unexpected write", {rf_addr, rf_wdata}, 0);
        else begin
          logic [14:0] e;
          e = wq.pop_front();
          chk({rf_addr, rf_wdata} == e, "R3/R4 write addr,data", {rf_addr, rf_wdata}, e);
        end
      end
      if (mon_mute) begin
        pl_run = 0;
        nbits  = 0;
      end else begin
        if (pull && !pull_prev && nbits == 0)
          chk(cyc - last_rise >= TURN, "R5 turnaround", cyc - last_rise, TURN);
        if (pull) pl_run++;
        else if (pull_prev) begin
          chk(pl_run == TX_ONE || pl_run == TX_ZERO, "R5 pull width", pl_run, TX_ONE);
          rbyte  = {(pl_run == TX_ONE), rbyte[7:1]};
          nbits++;
          pl_run = 0;
          if (nbits == 8) begin
            nbits = 0;
            if (rq.size() == 0) chk(1'b0, "R5 unexpected read byte", rbyte, 0);
            else begin
              logic [7:0] e;
              e = rq.pop_front();
              chk(rbyte == e, "R5 read byte", rbyte, e);
            end
          end
        end
      end
      pull_prev = pull;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(pull == 1'b0, "R1 reset pull", pull, 0);
    chk(rf_we == 1'b0, "R1 reset strobe", rf_we, 0);

    // R2 R3 R4: varied writes
    do_write(7'h12, 8'hA5);
    do_write(7'h7F, 8'h00);
    do_write(7'h00, 8'hFF);
    check_drained("R4");

    // R2: pulse widths at the decode thresholds
    wq.push_back({7'h2B, 8'h96});
    send_byte_edge({1'b1, 7'h2B});
    send_byte_edge(8'h96);
    repeat (6) @(posedge clk);
    check_drained("R2");

    // R3 R5: reads
    do_read(7'h05);
    do_read(7'h40);
    do_read(7'h7E);
    check_drained("R5");

    // R6: error pulses inside command and inside data
    host_pulse(H_ONE, H_GAP);
    host_pulse(H_ZERO, H_GAP);
    host_pulse(H_ONE, H_GAP);
    host_pulse(ZERO_MAX + 1, H_GAP);
    do_write(7'h33, 8'h5C);
    send_byte({1'b1, 7'h11});
    host_pulse(H_ONE, H_GAP);
    host_pulse(BRK - 1, H_GAP);
    do_write(7'h44, 8'hC3);
    check_drained("R6");

    // R7: exact-length break in the middle of write data
    send_byte({1'b1, 7'h21});
    for (int i = 0; i < 4; i++) host_pulse(H_ONE, H_GAP);
    host_pulse(BRK, RECOV + 5);
    do_write(7'h22, 8'h3E);
    check_drained("R7");

    // R7: break laid over a read in progress
    send_byte({1'b0, 7'h19});
    @(negedge pull);
    @(negedge pull);
    mon_mute = 1'b1;
    host_pulse(BRK + 5, 0);
    begin
      int seen = 0;
      repeat (RECOV + 40) begin
        @(negedge clk);
        if (pull) seen++;
      end
      chk(seen == 0, "R7 line released after break", seen, 0);
    end
    mon_mute = 1'b0;
    do_write(7'h19, 8'h81);
    check_drained("R7");

    // R8: pulses before recovery completes are ignored
    host_pulse(BRK + 3, 2);
    for (int i = 0; i < 3; i++) host_pulse(H_ONE, 4);
    repeat (RECOV + 5) @(posedge clk);
    do_write(7'h6A, 8'h0F);
    do_read(7'h6A);
    check_drained("R8");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule